// File: doc/BRIEF.md
# Paged Memory Management Unit

This block sits between an 8-bit CPU and a 1 MB memory array. It turns each 16-bit logical address into a 20-bit physical address. The logical space is split into sixteen 4 KB pages. The top four logical address bits choose an entry in the active page map, and that entry's 8-bit frame number replaces those bits. The low twelve bits pass straight through. Each entry also carries a write-protect flag. A CPU write to a protected page is held back from memory, and the block flags it on a separate inhibit output.

Four complete page maps are stored at the same time. One register selects the map used for translation, so switching between tasks takes a single register write. A second register selects which map the CPU is editing, so a map can be prepared while another one is live. An optional stage in front of the lookup relocates the 256-byte base page. When it is enabled and the upper logical byte is zero, a programmed value takes the place of that byte, and the result then goes through the page lookup.

The configuration window is a small block of byte registers, selected by `cfg_cs`. The system decoder is expected to place it in an unused I/O mirror area, for example at 0xDC80. The offset comes from `cpu_addr[5:0]`. Translation is purely combinational. Register writes take effect on the rising clock edge while `cfg_cs` and `cpu_we` are both high.

Top module: `paged_mmu`

## Requirements
- R1: Outside the configuration window, `mem_addr[19:12]` equals the frame number stored in the entry of the active map that is indexed by the translated address bits [15:12].
- R2: `mem_addr[11:0]` always equals the low twelve bits of the address after relocation. When relocation does not apply, that is `cpu_addr[11:0]`.
- R3: A write (`cpu_we`=1, `cfg_cs`=0) to a page whose entry has its protect flag set drives `mem_we`=0 and `mem_wr_inhibit`=1. A read of the same page is translated normally, with `mem_wr_inhibit`=0.
- R4: For an unprotected page outside the window, `mem_we` follows `cpu_we`, and `mem_wr_inhibit` is 0.
- R5: Writing a map number to the active-map register (offset 0x21, bits [1:0]) switches translation to that map from the next clock edge onward.
- R6: The edit-map register (offset 0x20, bits [1:0]) selects which map is reached through the entry registers. Offsets 0x00–0x0F hold the frame numbers for pages 0–15, and offsets 0x10–0x1F hold the protect flags for pages 0–15 in bit 0. Editing a map that is not active leaves translation unchanged.
- R7: Two entries, whether in the same map or in different maps, may hold the same frame number, and both then resolve to the same physical page.
- R8: When the enable bit (offset 0x23, bit 0) is set and `cpu_addr[15:8]` is 0x00, the base-page register (offset 0x22) replaces the upper byte before the page lookup. Addresses with a nonzero upper byte, and all addresses while the enable bit is clear, are not relocated.
- R9: After reset, every entry of every map is the identity mapping (page n maps to frame n, unprotected). The active map and edit map are both 0, the base-page register is 0, and relocation is disabled.
- R10: While `cfg_cs`=1, `mem_we` and `mem_wr_inhibit` are both 0, and `cpu_rdata` returns the addressed register (unused offsets read 0). While `cfg_cs`=0, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical address from the CPU; bits [5:0] give the register offset when `cfg_cs` is high |
| cpu_wdata | input | 8 | Write data from the CPU |
| cpu_we | input | 1 | CPU write strobe (1 = write, 0 = read) |
| cfg_cs | input | 1 | Selects the configuration register window |
| cpu_rdata | output | 8 | Register read-back data |
| mem_addr | output | 20 | Physical address to the memory array |
| mem_we | output | 1 | Gated write strobe to the memory array |
| mem_wr_inhibit | output | 1 | High when a write to a protected page was blocked |

## Verification
The checker assumes that `cfg_cs` and `cpu_we` are clean levels that stay stable between clock edges. It also assumes that a register write and a memory access never fall in the same cycle, because the window and memory share one bus. The bench drives every input on the falling edge, holds `cfg_cs` high for exactly one rising edge for each register write, and returns both strobes low afterwards. This keeps the bus inside those assumptions. Translation checks are sampled shortly after the falling edge, once the combinational path has settled and before the next capturing edge.

// File: rtl/pmmu_pkg.sv
package pmmu_pkg;
    localparam int LOG_W     = 16;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = LOG_W - OFF_W;
    localparam int NUM_PAGES = 1 << IDX_W;
    localparam int FRAME_W   = 8;
    localparam int PHYS_W    = FRAME_W + OFF_W;
    localparam int MAPS_DEF  = 4;
    localparam int REG_OFF_W = 6;

    localparam logic [REG_OFF_W-1:0] REG_EDIT   = 6'h20;
    localparam logic [REG_OFF_W-1:0] REG_ACTIVE = 6'h21;
    localparam logic [REG_OFF_W-1:0] REG_BASE   = 6'h22;
    localparam logic [REG_OFF_W-1:0] REG_CTRL   = 6'h23;

    typedef struct packed {
        logic               wp;
        logic [FRAME_W-1:0] frame;
    } entry_t;

    typedef enum logic [1:0] {
        GRP_FRAME = 2'b00,
        GRP_WP    = 2'b01,
        GRP_CTRL  = 2'b10,
        GRP_NONE  = 2'b11
    } reg_grp_e;

    function automatic entry_t identity_entry(input logic [IDX_W-1:0] idx);
        entry_t e;
        e.wp    = 1'b0;
        e.frame = FRAME_W'(idx);
        return e;
    endfunction

    function automatic logic in_base_page(input logic [LOG_W-1:0] a);
        return a[LOG_W-1:8] == '0;
    endfunction
endpackage

// File: rtl/pmmu_regfile.sv
module pmmu_regfile
    import pmmu_pkg::*;
#(
    parameter int NUM_MAPS = MAPS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs,
    input  logic                 we,
    input  logic [REG_OFF_W-1:0] off,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    input  logic [IDX_W-1:0]     lk_idx,
    output entry_t               lk_ent_o,
    output logic                 reloc_en,
    output logic [7:0]           base_page
);
    localparam int MAP_W = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1;

    logic [MAP_W-1:0] edit_q, active_q;
    logic [7:0]       base_q;
    logic             en_q;
    logic             wr;
    logic [IDX_W-1:0] ent_idx;
    reg_grp_e         grp;

    assign wr      = cs & we;
    assign ent_idx = off[IDX_W-1:0];
    assign grp     = reg_grp_e'(off[REG_OFF_W-1:IDX_W]);

    entry_t lk_ent [NUM_MAPS];
    entry_t rd_ent [NUM_MAPS];

    generate
        for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
            entry_t tbl [NUM_PAGES];
            logic   hit;
            assign hit = wr && (edit_q == MAP_W'(m));

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int p = 0; p < NUM_PAGES; p++)
                        tbl[p] <= identity_entry(IDX_W'(p));
                end else if (hit && grp == GRP_FRAME) begin
                    tbl[ent_idx].frame <= wdata;
                end else if (hit && grp == GRP_WP) begin
                    tbl[ent_idx].wp <= wdata[0];
                end
            end

            assign lk_ent[m] = tbl[lk_idx];
            assign rd_ent[m] = tbl[ent_idx];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            edit_q   <= '0;
            active_q <= '0;
            base_q   <= '0;
            en_q     <= 1'b0;
        end else if (wr) begin
            case (off)
                REG_EDIT:   edit_q   <= wdata[MAP_W-1:0];
                REG_ACTIVE: active_q <= wdata[MAP_W-1:0];
                REG_BASE:   base_q   <= wdata;
                REG_CTRL:   en_q     <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (cs) begin
            case (grp)
                GRP_FRAME: rdata = rd_ent[edit_q].frame;
                GRP_WP:    rdata = {7'b0, rd_ent[edit_q].wp};
                default: begin
                    case (off)
                        REG_EDIT:   rdata = 8'(edit_q);
                        REG_ACTIVE: rdata = 8'(active_q);
                        REG_BASE:   rdata = base_q;
                        REG_CTRL:   rdata = {7'b0, en_q};
                        default:    rdata = '0;
                    endcase
                end
            endcase
        end
    end

    assign lk_ent_o  = lk_ent[active_q];
    assign reloc_en  = en_q;
    assign base_page = base_q;
endmodule

// File: rtl/pmmu_reloc.sv
module pmmu_reloc
    import pmmu_pkg::*;
(
    input  logic             en,
    input  logic [7:0]       base,
    input  logic [LOG_W-1:0] addr_in,
    output logic [LOG_W-1:0] addr_out
);
    always_comb begin
        addr_out = addr_in;
        if (en && in_base_page(addr_in))
            addr_out = {base, addr_in[7:0]};
    end
endmodule

// File: rtl/pmmu_xlate.sv
module pmmu_xlate
    import pmmu_pkg::*;
(
    input  entry_t            ent,
    input  logic [LOG_W-1:0]  laddr,
    input  logic              cpu_we,
    input  logic              cfg_cs,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_wr_inhibit
);
    logic mem_wr;
    assign mem_wr         = cpu_we & ~cfg_cs;
    assign mem_addr       = {ent.frame, laddr[OFF_W-1:0]};
    assign mem_we         = mem_wr & ~ent.wp;
    assign mem_wr_inhibit = mem_wr & ent.wp;
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
    import pmmu_pkg::*;
#(
    parameter int NUM_MAPS = MAPS_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_we,
    input  logic        cfg_cs,
    output logic [7:0]  cpu_rdata,
    output logic [19:0] mem_addr,
    output logic        mem_we,
    output logic        mem_wr_inhibit
);
    entry_t           act_ent;
    logic             reloc_en;
    logic [7:0]       base_page;
    logic [LOG_W-1:0] reloc_addr;

    pmmu_regfile #(.NUM_MAPS(NUM_MAPS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cs        (cfg_cs),
        .we        (cpu_we),
        .off       (cpu_addr[REG_OFF_W-1:0]),
        .wdata     (cpu_wdata),
        .rdata     (cpu_rdata),
        .lk_idx    (reloc_addr[LOG_W-1:OFF_W]),
        .lk_ent_o  (act_ent),
        .reloc_en  (reloc_en),
        .base_page (base_page)
    );

    pmmu_reloc u_reloc (
        .en       (reloc_en),
        .base     (base_page),
        .addr_in  (cpu_addr),
        .addr_out (reloc_addr)
    );

    pmmu_xlate u_xlate (
        .ent            (act_ent),
        .laddr          (reloc_addr),
        .cpu_we         (cpu_we),
        .cfg_cs         (cfg_cs),
        .mem_addr       (mem_addr),
        .mem_we         (mem_we),
        .mem_wr_inhibit (mem_wr_inhibit)
    );
endmodule

// File: rtl/pmmu_checker.sv
module pmmu_checker (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic        cpu_we,
    input logic        cfg_cs,
    input logic [7:0]  cpu_rdata,
    input logic [19:0] mem_addr,
    input logic        mem_we,
    input logic        mem_wr_inhibit
);
    AST_WE_INHIBIT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_wr_inhibit)); // R3

    AST_WE_NEEDS_CPU: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cpu_we && !cfg_cs)); // R4

    AST_INHIBIT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_inhibit |-> (cpu_we && !cfg_cs)); // R3

    AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_cs |-> (!mem_we && !mem_wr_inhibit)); // R10

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cfg_cs |-> (cpu_rdata == 8'h00)); // R10

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:8] != 8'h00) |-> (mem_addr[11:0] == cpu_addr[11:0])); // R2

    AST_RESET_FLAT: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !cfg_cs) |-> (mem_addr == {4'h0, cpu_addr})); // R9
endmodule

bind paged_mmu pmmu_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_addr       (cpu_addr),
    .cpu_we         (cpu_we),
    .cfg_cs         (cfg_cs),
    .cpu_rdata      (cpu_rdata),
    .mem_addr       (mem_addr),
    .mem_we         (mem_we),
    .mem_wr_inhibit (mem_wr_inhibit)
);

// File: tb/paged_mmu_bench.sv
module paged_mmu_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        cfg_cs = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [19:0] mem_addr;
    logic        mem_we;
    logic        mem_wr_inhibit;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    paged_mmu u_paged_mmu (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cfg_cs(cfg_cs), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wr_inhibit(mem_wr_inhibit)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [5:0] off, input logic [7:0] val);
        @(negedge clk);
        cfg_cs = 1'b1; cpu_we = 1'b1; cpu_addr = {10'h372, off}; cpu_wdata = val;
        #1;
        chk("R10 window write no mem strobe", {30'b0, mem_we, mem_wr_inhibit}, 32'h0);
        @(negedge clk);
        cfg_cs = 1'b0; cpu_we = 1'b0; cpu_wdata = '0;
    endtask

    task automatic reg_rd(input logic [5:0] off, output logic [7:0] val);
        @(negedge clk);
        cfg_cs = 1'b1; cpu_we = 1'b0; cpu_addr = {10'h372, off};
        #1;
        val = cpu_rdata;
        @(negedge clk);
        cfg_cs = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input logic w);
        @(negedge clk);
        cfg_cs = 1'b0; cpu_we = w; cpu_addr = a;
        #1;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        access(16'h0000, 1'b0); chk("R9 identity page0", mem_addr, 32'h00000);
        access(16'h5ABC, 1'b0); chk("R9 identity page5", mem_addr, 32'h05ABC);
        access(16'hFFFF, 1'b1); chk("R9 identity page15", mem_addr, 32'h0FFFF);
        chk("R4 unprotected write passes", {30'b0, mem_we, mem_wr_inhibit}, 32'h2);
        chk("R10 rdata idle", cpu_rdata, 32'h0);
        reg_rd(6'h21, v); chk("R9 active map 0", v, 32'h0);
        reg_rd(6'h23, v); chk("R9 reloc off", v, 32'h0);
        reg_rd(6'h07, v); chk("R9 entry7 frame", v, 32'h07);
        reg_rd(6'h17, v); chk("R9 entry7 unprotected", v, 32'h0);
    endtask

    task automatic t_remap;
        reg_wr(6'h03, 8'hA7);
        access(16'h3456, 1'b0); chk("R1 page3 remapped", mem_addr[19:12], 32'hA7);
        chk("R2 offset kept", mem_addr[11:0], 32'h456);
        reg_wr(6'h04, 8'hA7);
        access(16'h4001, 1'b0); chk("R7 shared frame page4", mem_addr, 32'hA7001);
        access(16'h3001, 1'b0); chk("R7 shared frame page3", mem_addr, 32'hA7001);
    endtask

    task automatic t_protect;
        reg_wr(6'h13, 8'h01);
        access(16'h3000, 1'b1);
        chk("R3 protected write blocked", {30'b0, mem_we, mem_wr_inhibit}, 32'h1);
        access(16'h3000, 1'b0);
        chk("R3 protected read ok", {30'b0, mem_we, mem_wr_inhibit}, 32'h0);
        chk("R3 protected read addr", mem_addr, 32'hA7000);
        access(16'h2000, 1'b1);
        chk("R4 neighbour write passes", {30'b0, mem_we, mem_wr_inhibit}, 32'h2);
    endtask

    task automatic t_maps;
        logic [7:0] v;
        reg_wr(6'h20, 8'h02);
        reg_wr(6'h03, 8'h55);
        access(16'h3456, 1'b0); chk("R6 editing idle map no effect", mem_addr, 32'hA7456);
        reg_rd(6'h03, v); chk("R6 readback edited map", v, 32'h55);
        reg_wr(6'h21, 8'h02);
        access(16'h3456, 1'b0); chk("R5 switched to map2", mem_addr, 32'h55456);
        access(16'h3000, 1'b1);
        chk("R5 map2 page3 unprotected", {30'b0, mem_we, mem_wr_inhibit}, 32'h2);
        access(16'h4000, 1'b0); chk("R5 map2 page4 identity", mem_addr, 32'h04000);
        reg_wr(6'h21, 8'h00);
        access(16'h3456, 1'b0); chk("R5 back to map0", mem_addr, 32'hA7456);
    endtask

    task automatic t_reloc;
        logic [7:0] v;
        reg_wr(6'h22, 8'h3F);
        access(16'h0012, 1'b0); chk("R8 disabled no relocation", mem_addr, 32'h00012);
        reg_wr(6'h23, 8'h01);
        access(16'h0012, 1'b0); chk("R8 relocated then mapped", mem_addr, 32'hA7F12);
        access(16'h0112, 1'b0); chk("R8 nonzero upper byte kept", mem_addr, 32'h00112);
        reg_rd(6'h22, v); chk("R8 base readback", v, 32'h3F);
        reg_wr(6'h23, 8'h00);
        access(16'h0012, 1'b0); chk("R8 disabled again", mem_addr, 32'h00012);
    endtask

    task automatic t_window;
        logic [7:0] v;
        reg_rd(6'h30, v); chk("R10 unused offset reads 0", v, 32'h0);
        reg_rd(6'h20, v); chk("R10 edit map readback", v, 32'h02);
        @(negedge clk);
        cfg_cs = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h3000; cpu_wdata = 8'h30;
        #1;
        chk("R10 window write to protected-looking addr", {30'b0, mem_we, mem_wr_inhibit}, 32'h0);
        @(negedge clk);
        cfg_cs = 1'b0; cpu_we = 1'b0;
        reg_rd(6'h00, v); chk("R10 write hit entry0 of edit map", v, 32'h30);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_remap();
        t_protect();
        t_maps();
        t_reloc();
        t_window();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL timeout (all requirements) actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule